// File: doc/BRIEF.md
# Dual-Port Address Collision Arbiter

This block sits beside a two-port memory of 8K eight-bit words and watches the enable and 13-bit address of each port every clock cycle. When both ports are enabled on the same word, it lets one of them keep the word and pulls an active-low busy line on the other. The write strobe of the losing side is removed before it reaches the array, so the memory stays unchanged. A read from the losing side still goes ahead, but it is marked as carrying data that may not be valid.

The clock cycle stands in for the settling order of the inputs. A port counts as *held* when its enable was already active on the same address in the previous cycle. A port whose enable has just risen, or whose address has just changed, is *new*. The earlier port wins, and a tie goes to the left port. The grant stays with the winner for as long as it keeps its enable and address.

A mode input sets the role of the block. In master mode the block makes the busy decision itself. In slave mode it takes busy from external inputs, drives its own busy outputs high (push-pull, inactive), and uses the inputs only to block writes and to mark reads.

Top module: `dp_collision_arbiter`

## Requirements
- R1: In master mode with no collision (the two enables are not both high, or the addresses differ), both busy outputs are high.
- R2: On a collision where one port is held and the other is new, the held port keeps access. The new port sees its busy output low in the same cycle.
- R3: On a collision where both ports are new, the left port wins and busy_r_n goes low. The two busy outputs are never low together.
- R4: A write from the port whose busy is low is removed (its mem_we output is 0). A write from the winning port passes through.
- R5: A grant stays with its owner while the owner stays held, even when the other port arrives later. When the owner drops its enable or leaves the address, the collision ends and both busy outputs are high in that same cycle. If the owner moves onto the address where the other port is waiting, the waiting port takes the grant.
- R6: In slave mode (slave_mode=1), both busy outputs are 1. A low busy_in on a port removes that port's write. In master mode the busy_in inputs have no effect.
- R7: rd_unsafe of a port is 1 exactly when that port is enabled, is reading (we=0), and is busy (the internal busy in master mode, busy_in in slave mode).
- R8: mem_we of a port is never 1 while that port's enable is low.
- R9: After reset no port counts as held. A collision in the first cycle after reset is therefore a tie, and the left port wins it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slave_mode | input | 1 | 1 = busy is taken from busy_in_*; 0 = busy is decided locally |
| l_en | input | 1 | Left port enable, active high |
| l_addr | input | 13 | Left port word address |
| l_we | input | 1 | Left port write request |
| r_en | input | 1 | Right port enable, active high |
| r_addr | input | 13 | Right port word address |
| r_we | input | 1 | Right port write request |
| busy_in_l_n | input | 1 | External busy for left port (slave mode), active low |
| busy_in_r_n | input | 1 | External busy for right port (slave mode), active low |
| busy_l_n | output | 1 | Busy to left port, active low, push-pull |
| busy_r_n | output | 1 | Busy to right port, active low, push-pull |
| mem_we_l | output | 1 | Gated left write strobe to the array |
| mem_we_r | output | 1 | Gated right write strobe to the array |
| rd_unsafe_l | output | 1 | Left read data not guaranteed |
| rd_unsafe_r | output | 1 | Right read data not guaranteed |

## Verification
The hardest case to reach from the ports is a change of grant while the collision goes on. The owning port leaves the shared address and, in one cycle, lands on the address where the other port is waiting. The stimulus table reaches this by parking one port and moving the other through non-matching addresses and back onto the parked one. A reset asserted during a live collision, with the inputs held, checks that both ports come out of reset as new and that the tie goes to the left port.

// File: rtl/dp_arb_pkg.sv
package dp_arb_pkg;
  localparam int unsigned ADDR_W_DEF = 13;
  localparam int unsigned N_PORTS    = 2;
  localparam int unsigned P_LEFT     = 0;
  localparam int unsigned P_RIGHT    = 1;

  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_e;
endpackage

// File: rtl/dp_port_tracker.sv
// Remembers last cycle's enable/address of one port and reports whether the
// current request is a continuation (held) or a fresh arrival.
module dp_port_tracker #(
  parameter int unsigned ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [ADDR_W-1:0] addr,
  output logic              held
);
  logic              en_q;
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      addr_q <= '0;
    end else begin
      en_q   <= en;
      addr_q <= addr;
    end
  end

  assign held = en && en_q && (addr_q == addr);

  // a fresh enable can never be reported as held
  p_fresh_not_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en) |-> !held);
endmodule

// File: rtl/dp_grant_ctrl.sv
// Decides which port owns a colliding address and keeps that ownership.
module dp_grant_ctrl
  import dp_arb_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   master,
  input  logic   match,
  input  logic   l_held,
  input  logic   r_held,
  output owner_e grant
);
  owner_e owner_q;

  always_comb begin
    grant = OWN_NONE;
    if (master && match) begin
      if (owner_q == OWN_LEFT && l_held)        grant = OWN_LEFT;
      else if (owner_q == OWN_RIGHT && r_held)  grant = OWN_RIGHT;
      else if (l_held && !r_held)               grant = OWN_LEFT;
      else if (r_held && !l_held)               grant = OWN_RIGHT;
      else                                      grant = OWN_LEFT; // tie
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) owner_q <= OWN_NONE;
    else        owner_q <= grant;
  end

  // R5: an owner that stays held keeps the grant
  p_hold_owner_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (master && match && owner_q == OWN_RIGHT && r_held) |-> grant == OWN_RIGHT);
  // R3: both new -> left wins
  p_tie_left_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (master && match && !l_held && !r_held) |-> grant == OWN_LEFT);
  // R2: held beats new when nobody owns yet
  p_earlier_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (master && match && owner_q == OWN_NONE && r_held && !l_held) |-> grant == OWN_RIGHT);
endmodule

// File: rtl/dp_port_gate.sv
// Applies the effective busy of one port to its write strobe and read flag.
module dp_port_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic slave,
  input  logic en,
  input  logic we,
  input  logic local_busy,
  input  logic ext_busy_n,
  output logic mem_we,
  output logic rd_unsafe
);
  logic busy_eff;

  assign busy_eff  = slave ? !ext_busy_n : local_busy;
  assign mem_we    = en && we && !busy_eff;
  assign rd_unsafe = en && !we && busy_eff;

  // R8: no strobe without enable
  p_no_we_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !mem_we);
  // R7: flag only on reads
  p_flag_read_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_unsafe |-> (en && !we && !mem_we));
endmodule

// File: rtl/dp_collision_arbiter.sv
module dp_collision_arbiter
  import dp_arb_pkg::*;
#(
  parameter int unsigned ADDR_W = ADDR_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slave_mode,
  input  logic              l_en,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              l_we,
  input  logic              r_en,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic              r_we,
  input  logic              busy_in_l_n,
  input  logic              busy_in_r_n,
  output logic              busy_l_n,
  output logic              busy_r_n,
  output logic              mem_we_l,
  output logic              mem_we_r,
  output logic              rd_unsafe_l,
  output logic              rd_unsafe_r
);
  logic [N_PORTS-1:0] en_v, we_v, held_v, lbusy_v, ext_n_v, mwe_v, unsafe_v;
  logic [ADDR_W-1:0]  addr_v [N_PORTS];
  logic               match;
  owner_e             grant;

  assign en_v[P_LEFT]     = l_en;
  assign en_v[P_RIGHT]    = r_en;
  assign we_v[P_LEFT]     = l_we;
  assign we_v[P_RIGHT]    = r_we;
  assign addr_v[P_LEFT]   = l_addr;
  assign addr_v[P_RIGHT]  = r_addr;
  assign ext_n_v[P_LEFT]  = busy_in_l_n;
  assign ext_n_v[P_RIGHT] = busy_in_r_n;

  assign match = l_en && r_en && (l_addr == r_addr);

  generate
    for (genvar p = 0; p < N_PORTS; p++) begin : g_port
      dp_port_tracker #(.ADDR_W(ADDR_W)) u_trk (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (en_v[p]),
        .addr (addr_v[p]),
        .held (held_v[p])
      );
      dp_port_gate u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .slave     (slave_mode),
        .en        (en_v[p]),
        .we        (we_v[p]),
        .local_busy(lbusy_v[p]),
        .ext_busy_n(ext_n_v[p]),
        .mem_we    (mwe_v[p]),
        .rd_unsafe (unsafe_v[p])
      );
    end
  endgenerate

  dp_grant_ctrl u_grant (
    .clk   (clk),
    .rst_n (rst_n),
    .master(!slave_mode),
    .match (match),
    .l_held(held_v[P_LEFT]),
    .r_held(held_v[P_RIGHT]),
    .grant (grant)
  );

  assign lbusy_v[P_LEFT]  = (grant == OWN_RIGHT);
  assign lbusy_v[P_RIGHT] = (grant == OWN_LEFT);

  assign busy_l_n    = !lbusy_v[P_LEFT];
  assign busy_r_n    = !lbusy_v[P_RIGHT];
  assign mem_we_l    = mwe_v[P_LEFT];
  assign mem_we_r    = mwe_v[P_RIGHT];
  assign rd_unsafe_l = unsafe_v[P_LEFT];
  assign rd_unsafe_r = unsafe_v[P_RIGHT];

  // R3: busy is never low on both sides
  p_never_both_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_l_n || busy_r_n));
  // R1: without a collision nothing is busy
  p_no_collision_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(l_en && r_en && l_addr == r_addr) |-> (busy_l_n && busy_r_n));
  // R4: the busy side never writes in master mode
  p_loser_no_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!slave_mode && (!busy_l_n || !busy_r_n)) |-> !(mem_we_l && !busy_l_n) && !(mem_we_r && !busy_r_n));
  // R6: slave mode keeps busy outputs inactive
  p_slave_outputs_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    slave_mode |-> (busy_l_n && busy_r_n));
endmodule

// File: tb/tb_dp_collision_arbiter.sv
`timescale 1ns/1ps
module tb_dp_collision_arbiter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic slave_mode = 1'b0;
  logic l_en = 1'b0, l_we = 1'b0, r_en = 1'b0, r_we = 1'b0;
  logic [12:0] l_addr = '0, r_addr = '0;
  logic busy_in_l_n = 1'b1, busy_in_r_n = 1'b1;
  logic busy_l_n, busy_r_n, mem_we_l, mem_we_r, rd_unsafe_l, rd_unsafe_r;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dp_collision_arbiter dut (
    .clk(clk), .rst_n(rst_n), .slave_mode(slave_mode),
    .l_en(l_en), .l_addr(l_addr), .l_we(l_we),
    .r_en(r_en), .r_addr(r_addr), .r_we(r_we),
    .busy_in_l_n(busy_in_l_n), .busy_in_r_n(busy_in_r_n),
    .busy_l_n(busy_l_n), .busy_r_n(busy_r_n),
    .mem_we_l(mem_we_l), .mem_we_r(mem_we_r),
    .rd_unsafe_l(rd_unsafe_l), .rd_unsafe_r(rd_unsafe_r)
  );

  // {slave, l_en, l_addr, l_we, r_en, r_addr, r_we, bin_l_n, bin_r_n,
  //  expected {busy_l_n, busy_r_n, mem_we_l, mem_we_r, unsafe_l, unsafe_r}}
  localparam int NV = 19;
  localparam logic [38:0] VEC [NV] = '{
    {1'b0, 1'b0, 13'h0000, 1'b0, 1'b0, 13'h0000, 1'b0, 1'b1, 1'b1, 6'b110000}, // 0 R9 idle
    {1'b0, 1'b1, 13'h0100, 1'b0, 1'b1, 13'h0200, 1'b0, 1'b1, 1'b1, 6'b110000}, // 1 R1 differ
    {1'b0, 1'b1, 13'h0100, 1'b0, 1'b1, 13'h0100, 1'b1, 1'b1, 1'b1, 6'b100000}, // 2 R2 R4 right late
    {1'b0, 1'b1, 13'h0100, 1'b1, 1'b1, 13'h0100, 1'b0, 1'b1, 1'b1, 6'b101001}, // 3 R5 R7 hold
    {1'b0, 1'b0, 13'h0100, 1'b0, 1'b1, 13'h0100, 1'b0, 1'b1, 1'b1, 6'b110000}, // 4 R5 release
    {1'b0, 1'b1, 13'h0100, 1'b1, 1'b1, 13'h0100, 1'b0, 1'b1, 1'b1, 6'b010000}, // 5 R2 left late
    {1'b0, 1'b1, 13'h0101, 1'b1, 1'b1, 13'h0100, 1'b1, 1'b1, 1'b1, 6'b111100}, // 6 R1 R5 leave
    {1'b0, 1'b1, 13'h1FFF, 1'b1, 1'b1, 13'h1FFF, 1'b1, 1'b1, 1'b1, 6'b101000}, // 7 R3 tie
    {1'b0, 1'b1, 13'h1FFF, 1'b1, 1'b1, 13'h1FFF, 1'b1, 1'b1, 1'b1, 6'b101000}, // 8 R5 hold tie
    {1'b0, 1'b1, 13'h0005, 1'b1, 1'b1, 13'h1FFF, 1'b0, 1'b1, 1'b1, 6'b111000}, // 9 R1
    {1'b0, 1'b1, 13'h1FFF, 1'b0, 1'b1, 13'h1FFF, 1'b0, 1'b1, 1'b1, 6'b010010}, // 10 R2 R7
    {1'b0, 1'b1, 13'h0000, 1'b1, 1'b1, 13'h0000, 1'b1, 1'b1, 1'b1, 6'b101000}, // 11 R3 both move
    {1'b0, 1'b1, 13'h0002, 1'b1, 1'b1, 13'h0000, 1'b1, 1'b1, 1'b1, 6'b111100}, // 12 R1
    {1'b0, 1'b1, 13'h0000, 1'b1, 1'b1, 13'h0000, 1'b1, 1'b1, 1'b1, 6'b010100}, // 13 R5 onto waiter
    {1'b0, 1'b0, 13'h0000, 1'b1, 1'b0, 13'h0000, 1'b1, 1'b1, 1'b1, 6'b110000}, // 14 R8 no enable
    {1'b1, 1'b1, 13'h0010, 1'b1, 1'b1, 13'h0010, 1'b1, 1'b1, 1'b0, 6'b111000}, // 15 R6 slave
    {1'b1, 1'b1, 13'h0010, 1'b0, 1'b1, 13'h0010, 1'b0, 1'b0, 1'b1, 6'b110010}, // 16 R6 R7 slave
    {1'b1, 1'b1, 13'h0010, 1'b1, 1'b1, 13'h0010, 1'b1, 1'b1, 1'b1, 6'b111100}, // 17 R6 both write
    {1'b0, 1'b1, 13'h0010, 1'b1, 1'b1, 13'h0010, 1'b1, 1'b0, 1'b1, 6'b101000}  // 18 R6 inputs ignored
  };
  localparam int REQ [NV] = '{9, 1, 2, 5, 5, 2, 1, 3, 5, 1, 7, 3, 1, 5, 8, 6, 7, 6, 6};

  task automatic apply(input logic [38:0] v);
    slave_mode  = v[38];
    l_en        = v[37];
    l_addr      = v[36:24];
    l_we        = v[23];
    r_en        = v[22];
    r_addr      = v[21:9];
    r_we        = v[8];
    busy_in_l_n = v[7];
    busy_in_r_n = v[6];
  endtask

  task automatic compare(input string tag, input logic [5:0] exp);
    logic [5:0] act;
    act = {busy_l_n, busy_r_n, mem_we_l, mem_we_r, rd_unsafe_l, rd_unsafe_r};
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R9: outputs during reset with idle inputs
    compare("R9 reset idle", 6'b110000);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      @(posedge clk);
      #1 apply(VEC[i]);
      #2 compare($sformatf("R%0d vector %0d", REQ[i], i), VEC[i][5:0]);
    end
    // R9: reset in a live collision; both come out new, left wins
    @(posedge clk);
    #1 rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    #2 compare("R9 tie after reset", 6'b101000);
    // R5: next cycle the left grant is kept while both stay
    @(posedge clk);
    #3 compare("R5 grant kept after reset", 6'b101000);
    // R5: left drops its enable, busy on the right releases at once
    @(posedge clk);
    #1 l_en = 1'b0;
    #2 compare("R5 owner drop", 6'b110100);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule